// File: doc/BRIEF.md
# Flash Operation Engine with Status Polling

This block carries out the long-running write operations of a byte-wide flash model. A command decoder sends it single-cycle request pulses. A program request carries one address and one data byte. An erase request carries an inclusive address range. A whole-chip erase is the same request with the range set to the full array. The block holds the byte array in registers, times each operation with its own counter, and drives a write enable toward the array for every byte it changes.

Reads come in as a strobe with an address. The result appears on the read data port in the following cycle. While no operation is running, a read returns the stored byte. While an operation runs, a read returns a status byte instead. Software uses that byte to detect the end of the operation in two ways: bit 7 differs from the byte being written until the operation finishes, and bit 6 changes on every read.

Programming can only clear bits. Only an erase sets bits back to ones, and its countdown is followed by a sweep that writes one byte per clock. Pulling the active-low reset abandons any running operation. The engine then returns to read mode without finishing the write.

Top module: `flash_op_engine`

## Requirements
- R1: A completed program leaves the target byte equal to its previous value ANDed with the request data, so bits can go from 1 to 0 but never from 0 to 1.
- R2: A completed erase writes FF to every byte from the first to the last address inclusive and leaves every other byte unchanged. When the first address is greater than the last, only the first address is erased.
- R3: When a program request is accepted at a clock edge, busy is high for exactly PROG_CYCLES cycles starting after that edge. The write enable is high for exactly one cycle, the last one of that window.
- R4: An accepted erase of N bytes keeps busy high for ERASE_CYCLES + N cycles. The write enable is high for exactly N of those cycles, and busy falls only after a cycle with the write enable high.
- R5: When busy is low at the edge where the read strobe is sampled, read data holds the stored byte at the read address from the next cycle. Read data does not change in cycles without a strobe.
- R6: When busy is high at the edge where the read strobe is sampled, read data becomes a status byte with these fields:
  - bit 7 is the inverse of bit 7 of the program data, or 0 during an erase;
  - bit 6 is the toggle bit;
  - bits 5 to 0 are zero.
- R7: The toggle bit starts at 0 after reset and inverts after every read taken while busy. Reads taken while idle leave it unchanged.
- R8: Program and erase requests that arrive while busy is high are ignored and leave no trace in the array.
- R9: Driving reset low during an operation abandons it. Busy and read data go to zero, the target bytes keep their old contents, and normal reads resume once reset is released.
- R10: When program and erase requests arrive in the same idle cycle, the program is carried out and the erase is dropped.
- R11: During and right after reset, busy, the write enable and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also aborts a running operation |
| prog_req | input | 1 | One-cycle program request |
| prog_addr | input | ADDR_W | Byte address to program |
| prog_data | input | DATA_W | Data to program (ANDed into the byte) |
| erase_req | input | 1 | One-cycle erase request |
| erase_first | input | ADDR_W | First address of the erase range |
| erase_last | input | ADDR_W | Last address of the erase range (inclusive) |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Stored byte when idle, status byte when busy |
| busy | output | 1 | High from an accepted request until its final array write |
| arr_we | output | 1 | Write enable toward the byte array, one cycle per byte written |

## Verification
Programming is tried with repeated writes to the same byte. This separates true AND behaviour from plain overwrite. Erase is tried with the full range, short ranges and an inverted range, so that the inclusive end and the single-byte fallback show up in both the byte contents and the count of write-enable cycles. Status reads are issued inside program and erase windows and between them. This tells apart a toggle driven by busy reads from one driven by clocks or by any read, and it shows the inverted bit 7 for data with either value of that bit. Requests during busy, same-cycle program and erase, and reset in the middle of both kinds of operation each leave a byte whose value can tell whether the operation was carried out. A seeded random mix of these operations is then checked against a bench model of the array.

// File: rtl/fe_pkg.sv
package fe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PROG  = 2'd1,
      ST_ERWT  = 2'd2,
      ST_SWEEP = 2'd3
   } eng_state_t;
endpackage

// File: rtl/fe_timer.sv
module fe_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R3/R4: the count only ever moves down between loads
   assert_timer_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fe_status.sv
module fe_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic              poll_bit,
   output logic [DATA_W-1:0] status
);
   logic tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tog <= 1'b0;
      else if (rd_hit) tog <= ~tog;
   end

   always_comb begin
      status           = '0;
      status[DATA_W-1] = poll_bit;
      status[DATA_W-2] = tog;
   end

   assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (tog != $past(tog)));
   assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(tog));
endmodule

// File: rtl/fe_array.sv
module fe_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 8,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_req,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              erase_req,
   input  logic [ADDR_W-1:0] erase_first,
   input  logic [ADDR_W-1:0] erase_last,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              arr_we
);
   import fe_pkg::*;

   localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(LONGEST + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2 to hold the status bits");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and 10");
      end
      if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_cycles
         $error("operation durations must be at least one cycle");
      end
   endgenerate

   eng_state_t        st;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data;
   logic [ADDR_W-1:0] er_last;
   logic [ADDR_W-1:0] sweep_ptr;

   logic              accept_prog, accept_er, tmr_load, tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   logic              prog_fire, sweep_fire, sweep_done;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data, old_byte, arr_rdata, status;
   logic              poll_bit;

   assign busy        = (st != ST_IDLE);
   assign accept_prog = (st == ST_IDLE) && prog_req;
   assign accept_er   = (st == ST_IDLE) && !prog_req && erase_req;
   assign tmr_load    = accept_prog || accept_er;
   assign tmr_val     = accept_prog ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);

   assign prog_fire   = (st == ST_PROG) && tmr_zero;
   assign sweep_fire  = (st == ST_SWEEP);
   assign sweep_done  = (sweep_ptr >= er_last);
   assign arr_we      = prog_fire || sweep_fire;
   assign wr_addr     = sweep_fire ? sweep_ptr : lat_addr;
   assign wr_data     = sweep_fire ? {DATA_W{1'b1}} : (old_byte & lat_data);
   assign poll_bit    = (st == ST_PROG) ? ~lat_data[DATA_W-1] : 1'b0;

   fe_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   fe_status #(.DATA_W(DATA_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_hit   (rd_stb && busy),
      .poll_bit (poll_bit),
      .status   (status)
   );

   fe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .we      (arr_we),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .raddr_a (rd_addr),
      .rdata_a (arr_rdata),
      .raddr_b (lat_addr),
      .rdata_b (old_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         lat_addr  <= '0;
         lat_data  <= '0;
         er_last   <= '0;
         sweep_ptr <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept_prog) begin
                  lat_addr <= prog_addr;
                  lat_data <= prog_data;
                  st       <= ST_PROG;
               end else if (accept_er) begin
                  sweep_ptr <= erase_first;
                  er_last   <= erase_last;
                  st        <= ST_ERWT;
               end
            end
            ST_PROG:  if (tmr_zero) st <= ST_IDLE;
            ST_ERWT:  if (tmr_zero) st <= ST_SWEEP;
            ST_SWEEP: begin
               if (sweep_done) st <= ST_IDLE;
               else            sweep_ptr <= sweep_ptr + 1'b1;
            end
            default:  st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= busy ? status : arr_rdata;
   end

   assert_prog_and_R1: assert property (@(posedge clk) disable iff (!rst_n)
      prog_fire |=> (old_byte == $past(old_byte & lat_data)));
   assert_we_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);
   assert_busy_ends_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(arr_we));
   assert_status_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && busy) |=> (rd_data[DATA_W-3:0] == '0));
   assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (prog_req || erase_req)) |=> ($stable(lat_data) && $stable(er_last)));
endmodule

// File: tb/tb_flash_op_engine.sv
module tb_flash_op_engine;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int PC = 8;
   localparam int EC = 24;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prog_req = 1'b0;
   logic [AW-1:0] prog_addr = '0;
   logic [DW-1:0] prog_data = '0;
   logic          erase_req = 1'b0;
   logic [AW-1:0] erase_first = '0;
   logic [AW-1:0] erase_last = '0;
   logic          rd_stb = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy;
   logic          arr_we;

   flash_op_engine #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
      .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
      .prog_data(prog_data), .erase_req(erase_req), .erase_first(erase_first),
      .erase_last(erase_last), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .arr_we(arr_we)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   int we_cnt = 0;
   int tests = 0;
   int fails = 0;
   always @(posedge clk) cyc++;
   always @(negedge clk) if (arr_we) we_cnt++;

   logic [DW-1:0] mem_m [DEPTH];
   bit      tog_m = 1'b0;
   bit      op_active = 1'b0;
   int      op_end = 0;
   bit      op_b7 = 1'b0;
   int      pend_kind = 0;
   int      pend_a, pend_lo, pend_hi;
   logic [DW-1:0] pend_d;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int erase_len(input int lo, input int hi);
      return (hi >= lo) ? (hi - lo + 1) : 1;
   endfunction

   function automatic logic [DW-1:0] status_of(input bit b7, input bit t);
      return {b7, t, 6'b000000};
   endfunction

   task automatic settle(input int e);
      if (op_active && e > op_end) begin
         if (pend_kind == 1) mem_m[pend_a] = mem_m[pend_a] & pend_d;
         else if (pend_kind == 2)
            for (int i = pend_lo; i < pend_lo + erase_len(pend_lo, pend_hi); i++) mem_m[i] = 8'hFF;
         op_active = 1'b0;
         pend_kind = 0;
      end
   endtask

   task automatic issue(input bit p, input bit e, input int a, input int d, input int lo, input int hi);
      int s;
      @(negedge clk);
      prog_req = p; erase_req = e;
      prog_addr = AW'(a); prog_data = DW'(d);
      erase_first = AW'(lo); erase_last = AW'(hi);
      s = cyc + 1;
      settle(s);
      if (!(op_active && s <= op_end)) begin
         if (p) begin
            op_active = 1'b1; op_end = s + PC; op_b7 = ~d[7];
            pend_kind = 1; pend_a = a; pend_d = DW'(d);
         end else if (e) begin
            op_active = 1'b1; op_end = s + EC + erase_len(lo, hi); op_b7 = 1'b0;
            pend_kind = 2; pend_lo = lo; pend_hi = hi;
         end
      end
      @(negedge clk);
      prog_req = 1'b0; erase_req = 1'b0;
   endtask

   task automatic rd(input int a, input string req);
      int e;
      logic [DW-1:0] exp;
      @(negedge clk);
      rd_stb = 1'b1; rd_addr = AW'(a);
      e = cyc + 1;
      @(negedge clk);
      rd_stb = 1'b0;
      settle(e);
      if (op_active && e <= op_end) begin
         exp = status_of(op_b7, tog_m);
         tog_m = ~tog_m;
      end else exp = mem_m[a];
      chk(rd_data === exp, req, int'(rd_data), int'(exp));
   endtask

   task automatic wait_idle();
      while (op_active && cyc < op_end) @(negedge clk);
      settle(cyc + 1);
   endtask

   task automatic measure(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      op_active = 1'b0; pend_kind = 0; tog_m = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R9 busy in reset", busy, 0);
      chk(rd_data == '0, "R9 rd_data in reset", rd_data, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n, w0, k;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R11 busy", busy, 0);
      chk(arr_we == 1'b0, "R11 arr_we", arr_we, 0);
      chk(rd_data == '0, "R11 rd_data", rd_data, 0);
      rst_n = 1'b1;

      // full-range erase (R4, R2)
      w0 = we_cnt;
      issue(0, 1, 0, 0, 0, DEPTH - 1);
      measure(n);
      chk(n == EC + DEPTH, "R4 erase busy length", n, EC + DEPTH);
      chk(we_cnt - w0 == DEPTH, "R4 erase write count", we_cnt - w0, DEPTH);
      rd(0, "R2 full erase byte 0");
      rd(37, "R2 full erase byte 37");
      rd(DEPTH - 1, "R2 full erase last byte");

      // program timing and AND semantics (R3, R1)
      w0 = we_cnt;
      issue(1, 0, 3, 8'h5A, 0, 0);
      measure(n);
      chk(n == PC, "R3 program busy length", n, PC);
      chk(we_cnt - w0 == 1, "R3 program write count", we_cnt - w0, 1);
      rd(3, "R1 first program");
      issue(1, 0, 3, 8'hF0, 0, 0);
      wait_idle();
      rd(3, "R1 second program ANDs");

      // status while busy (R6, R7)
      issue(1, 0, 9, 8'h3C, 0, 0);
      rd(9, "R6 poll bit7 inverted");
      rd(9, "R7 toggle flips");
      rd(20, "R6 R7 other address while busy");
      wait_idle();
      rd(9, "R6 true data after program");
      rd(9, "R7 idle read no toggle");
      issue(1, 0, 10, 8'hC3, 0, 0);
      rd(10, "R6 poll bit7 for data bit7 high R7");
      wait_idle();
      issue(0, 1, 0, 0, 40, 41);
      rd(40, "R6 erase status bit7 zero");
      wait_idle();

      // requests while busy (R8)
      issue(1, 0, 11, 8'h00, 0, 0);
      issue(1, 0, 12, 8'h00, 0, 0);
      issue(0, 1, 0, 0, 3, 3);
      wait_idle();
      rd(12, "R8 program while busy ignored");
      rd(3, "R8 erase while busy ignored");
      rd(11, "R8 first program done");

      // reset abort (R9)
      issue(1, 0, 13, 8'h00, 0, 0);
      repeat (3) @(negedge clk);
      do_reset();
      rd(13, "R9 aborted program leaves byte");
      issue(0, 1, 0, 0, 3, 12);
      repeat (10) @(negedge clk);
      do_reset();
      rd(3, "R9 aborted erase leaves byte 3");
      rd(11, "R9 aborted erase leaves byte 11");

      // same-cycle requests (R10)
      issue(1, 0, 22, 8'h00, 0, 0);
      wait_idle();
      issue(1, 1, 20, 8'h0F, 21, 25);
      measure(n);
      chk(n == PC, "R10 program wins busy length", n, PC);
      settle(cyc + 1);
      rd(20, "R10 program done");
      rd(22, "R10 erase dropped");

      // inverted range (R2)
      for (int i = 28; i < 32; i++) begin
         issue(1, 0, i, 8'h11, 0, 0);
         wait_idle();
      end
      w0 = we_cnt;
      issue(0, 1, 0, 0, 30, 28);
      wait_idle();
      chk(we_cnt - w0 == 1, "R2 inverted range writes one", we_cnt - w0, 1);
      rd(30, "R2 inverted range first erased");
      rd(29, "R2 inverted range below kept");
      rd(31, "R2 inverted range above kept");

      // hold without strobe (R5)
      rd(22, "R5 read");
      for (int i = 0; i < 4; i++) begin
         rd_addr = AW'(i + 40);
         @(negedge clk);
      end
      chk(rd_data == 8'h00, "R5 hold without strobe", rd_data, 0);

      // seeded random mix
      for (int it = 0; it < 80; it++) begin
         k = $urandom % 4;
         if (k < 2) issue(1, 0, $urandom % DEPTH, $urandom % 256, 0, 0);
         else if (k == 2) begin
            int lo;
            int hi;
            lo = $urandom % DEPTH;
            hi = lo + ($urandom % 6);
            if (hi > DEPTH - 1) hi = DEPTH - 1;
            issue(0, 1, 0, 0, lo, hi);
         end
         for (int r = 0; r < int'($urandom % 4); r++) rd($urandom % DEPTH, "R5 R6 random read");
         if ($urandom % 5 == 0) issue(1, 0, $urandom % DEPTH, $urandom % 256, 0, 0);
         wait_idle();
         rd($urandom % DEPTH, "R1 R2 random check");
         rd($urandom % DEPTH, "R1 R2 random check");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule